// File: doc/BRIEF.md
# ACPI Button Event Controller

This block turns two active-low front-panel buttons, one for power and one for sleep, into ACPI event status. Each pin is synchronised and then filtered. The filter accepts a new level only after the pin has held that level for a set number of consecutive millisecond ticks. The filtered power-button level is driven back out on a pin, so that an optional external ACPI controller can follow it.

Each button keeps two sticky status bits: a PM1 bit and a general-purpose-event (GPE) bit. A filtered low level sets the GPE bit every cycle it is present. It sets the PM1 bit only when that button's PM event enable is high. A clear strobe aimed at either bit of a button clears both bits of that button. The clear is ignored while the filtered level is still low.

Power-button detection is held off after standby power comes up. The hold-off lasts a set number of millisecond ticks. An accepted power press raises a wake request whenever main power is off. In legacy mode, a press while main power is on does not set status. Instead it raises a power-off request and holds both power-button status bits clear.

Top module: `btn_evt_ctrl`

## Requirements
- R1: A pin level reaches the filtered output only after the synchronised pin has differed from the filtered level on DEB_TICKS consecutive cycles that carry a millisecond tick. A shorter glitch is ignored. Cycles without a tick make no progress.
- R2: `pwr_btn_fwd_n` equals the filtered power-button level: 0 means pressed, 1 means released. It is 1 out of reset and is not gated by the standby hold-off.
- R3: An accepted low level sets that button's GPE bit. It sets that button's PM1 bit only when the button's PM enable input is 1.
- R4: Status bits stay set after the button is released, until they are cleared.
- R5: A 1 on either clear strobe of a button clears both status bits of that button on the next edge. The other button's bits are unaffected.
- R6: A clear strobe has no effect while that button's filtered level is still low.
- R7: Power-button status, wake and off requests are blocked until HOLD_TICKS ticks have passed with `sb_pwrgood` high. A low `sb_pwrgood` restarts the hold-off. The sleep button is not gated.
- R8: `wake_req` is 1 while an accepted power press is present and `main_pwr_on` is 0. It is 0 while main power is on.
- R9: With `legacy_mode`=1 and `main_pwr_on`=1, an accepted power press drives `off_req` to 1. It also holds both power-button status bits at 0. Sleep-button status is unaffected.
- R10: After reset, all status bits, `off_req` and `wake_req` are 0, and `pwr_btn_fwd_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pwr_btn_n | input | 1 | Power button pin, low when pressed |
| slp_btn_n | input | 1 | Sleep button pin, low when pressed |
| sb_pwrgood | input | 1 | Standby power valid |
| main_pwr_on | input | 1 | Main power is on |
| pwr_pm_en | input | 1 | Allows the power-button PM1 bit to set |
| slp_pm_en | input | 1 | Allows the sleep-button PM1 bit to set |
| legacy_mode | input | 1 | Power button forces power-off while main power is on |
| pwr_pm_clr | input | 1 | Write-1 strobe to the power PM1 bit |
| pwr_gpe_clr | input | 1 | Write-1 strobe to the power GPE bit |
| slp_pm_clr | input | 1 | Write-1 strobe to the sleep PM1 bit |
| slp_gpe_clr | input | 1 | Write-1 strobe to the sleep GPE bit |
| pwr_pm_sts | output | 1 | Power-button PM1 status |
| pwr_gpe_sts | output | 1 | Power-button GPE status |
| slp_pm_sts | output | 1 | Sleep-button PM1 status |
| slp_gpe_sts | output | 1 | Sleep-button GPE status |
| pwr_btn_fwd_n | output | 1 | Filtered power-button level |
| off_req | output | 1 | Request for the off sleep state |
| wake_req | output | 1 | Wake request from the power button |

## Verification
The bench builds the block with DEB_TICKS=4, HOLD_TICKS=8 and SYNC_STAGES=2. These values let a full filter window and the whole standby hold-off pass in a dozen cycles. That makes it cheap to probe a glitch shorter than the window, a press during the hold-off, and a hold-off restarted by a standby drop. With the tick held constant, the bench can also stall the filter entirely and show that a press longer than the window is still not accepted. The small settings leave every input combination in the vector table, including both legacy cases, reachable within a short run.

// File: rtl/btn_evt_pkg.sv
package btn_evt_pkg;
   localparam int NUM_BTN = 2;
   localparam int BTN_PWR = 0;
   localparam int BTN_SLP = 1;

   typedef struct packed {
      logic pm;
      logic gpe;
   } sts_pair_t;
endpackage

// File: rtl/btn_filter.sv
module btn_filter #(
   parameter int DEB_TICKS   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic pin_n,
   output logic level_n
);
   localparam int CNT_W = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;

   generate
      if (DEB_TICKS < 2) begin : g_bad_deb
         $error("btn_filter: DEB_TICKS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("btn_filter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       run_q;
   logic                   level_q;
   logic                   pin_s;

   assign pin_s   = sync_q[SYNC_STAGES-1];
   assign level_n = level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         level_q <= 1'b1;
      end else if (pin_s == level_q) begin
         run_q <= '0;
      end else if (ms_tick) begin
         if (run_q == CNT_W'(DEB_TICKS - 1)) begin
            run_q   <= '0;
            level_q <= pin_s;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   // R1: without a tick the accepted level never moves
   p_no_tick_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_tick |=> $stable(level_q));
   // R1: a level change only follows a disagreeing synchronised pin
   p_change_needs_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_s == level_q) |=> $stable(level_q));
endmodule

// File: rtl/sb_holdoff.sv
module sb_holdoff #(
   parameter int HOLD_TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic sb_good,
   output logic ready
);
   generate
      if (HOLD_TICKS < 0) begin : g_bad_hold
         $error("sb_holdoff: HOLD_TICKS must not be negative");
      end

      if (HOLD_TICKS == 0) begin : g_pass
         assign ready = sb_good;
      end else begin : g_count
         localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
         logic [HW-1:0] cnt_q;
         logic          rdy_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               rdy_q <= 1'b0;
            end else if (!sb_good) begin
               cnt_q <= '0;
               rdy_q <= 1'b0;
            end else if (!rdy_q && ms_tick) begin
               if (cnt_q == HW'(HOLD_TICKS - 1)) begin
                  rdy_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         assign ready = rdy_q;

         // R7: losing standby power withdraws readiness on the next edge
         p_sb_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !sb_good |=> !rdy_q);
      end
   endgenerate
endmodule

// File: rtl/btn_status_pair.sv
module btn_status_pair
   import btn_evt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active,
   input  logic      kill,
   input  logic      pm_en,
   input  logic      clr,
   output sts_pair_t sts
);
   sts_pair_t sts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
      end else if (kill) begin
         sts_q <= '0;
      end else if (active) begin
         sts_q.gpe <= 1'b1;
         sts_q.pm  <= sts_q.pm | pm_en;
      end else if (clr) begin
         sts_q <= '0;
      end
   end

   assign sts = sts_q;

   // R6: a clear during a held press leaves the GPE bit set
   p_clear_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !kill) |=> sts_q.gpe);
   // R5: a clear while released drops both bits together
   p_pair_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !active && !kill) |=> (sts_q == '0));
   // R3: the PM1 bit only rises when its enable was high
   p_pm_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q.pm) |-> $past(pm_en));
   // R4: with neither press, clear nor kill, the bits hold
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clr && !kill) |=> $stable(sts_q));
endmodule

// File: rtl/btn_evt_ctrl.sv
module btn_evt_ctrl
   import btn_evt_pkg::*;
#(
   parameter int DEB_TICKS   = 16,
   parameter int HOLD_TICKS  = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic pwr_btn_n,
   input  logic slp_btn_n,
   input  logic sb_pwrgood,
   input  logic main_pwr_on,
   input  logic pwr_pm_en,
   input  logic slp_pm_en,
   input  logic legacy_mode,
   input  logic pwr_pm_clr,
   input  logic pwr_gpe_clr,
   input  logic slp_pm_clr,
   input  logic slp_gpe_clr,
   output logic pwr_pm_sts,
   output logic pwr_gpe_sts,
   output logic slp_pm_sts,
   output logic slp_gpe_sts,
   output logic pwr_btn_fwd_n,
   output logic off_req,
   output logic wake_req
);
   logic [NUM_BTN-1:0] pin_n, lvl_n, ready, active, kill, pm_en, clr;
   sts_pair_t          sts [NUM_BTN];
   logic               ho_ready, pwr_act, legacy_hit;
   logic               off_q, wake_q;

   assign pin_n[BTN_PWR] = pwr_btn_n;
   assign pin_n[BTN_SLP] = slp_btn_n;
   assign pm_en[BTN_PWR] = pwr_pm_en;
   assign pm_en[BTN_SLP] = slp_pm_en;
   assign clr[BTN_PWR]   = pwr_pm_clr | pwr_gpe_clr;
   assign clr[BTN_SLP]   = slp_pm_clr | slp_gpe_clr;

   sb_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_holdoff (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .sb_good(sb_pwrgood), .ready(ho_ready));

   assign pwr_act    = ~lvl_n[BTN_PWR] & ho_ready;
   assign legacy_hit = pwr_act & legacy_mode & main_pwr_on;

   generate
      for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
         btn_filter #(.DEB_TICKS(DEB_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
            .pin_n(pin_n[b]), .level_n(lvl_n[b]));

         if (b == BTN_PWR) begin : g_gate_pwr
            assign ready[b] = ho_ready;
            assign kill[b]  = legacy_hit;
         end else begin : g_gate_free
            assign ready[b] = 1'b1;
            assign kill[b]  = 1'b0;
         end

         assign active[b] = ~lvl_n[b] & ready[b] & ~kill[b];

         btn_status_pair u_sts (
            .clk(clk), .rst_n(rst_n), .active(active[b]), .kill(kill[b]),
            .pm_en(pm_en[b]), .clr(clr[b]), .sts(sts[b]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         off_q  <= legacy_hit;
         wake_q <= pwr_act & ~main_pwr_on;
      end
   end

   assign pwr_pm_sts    = sts[BTN_PWR].pm;
   assign pwr_gpe_sts   = sts[BTN_PWR].gpe;
   assign slp_pm_sts    = sts[BTN_SLP].pm;
   assign slp_gpe_sts   = sts[BTN_SLP].gpe;
   assign pwr_btn_fwd_n = lvl_n[BTN_PWR];
   assign off_req       = off_q;
   assign wake_req      = wake_q;

   // R9: a legacy press forces off and leaves power status clear
   p_legacy_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_hit |=> (off_req && !pwr_pm_sts && !pwr_gpe_sts));
   // R8: no wake request is raised while main power is on
   p_no_wake_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      main_pwr_on |=> !wake_req);
   // R7: without hold-off completion the power GPE bit cannot rise
   p_holdoff_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ho_ready |=> !$rose(pwr_gpe_sts));
endmodule

// File: tb/test_btn_evt_ctrl.sv
module test_btn_evt_ctrl;
   localparam int DEB  = 4;
   localparam int HOLD = 8;
   localparam int WAIT = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b1;
   logic pwr_btn_n = 1'b1, slp_btn_n = 1'b1;
   logic sb_pwrgood = 1'b0, main_pwr_on = 1'b0;
   logic pwr_pm_en = 1'b0, slp_pm_en = 1'b0, legacy_mode = 1'b0;
   logic pwr_pm_clr = 1'b0, pwr_gpe_clr = 1'b0, slp_pm_clr = 1'b0, slp_gpe_clr = 1'b0;
   logic pwr_pm_sts, pwr_gpe_sts, slp_pm_sts, slp_gpe_sts;
   logic pwr_btn_fwd_n, off_req, wake_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   btn_evt_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .SYNC_STAGES(2)) i_btn_evt_ctrl (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .pwr_btn_n(pwr_btn_n), .slp_btn_n(slp_btn_n),
      .sb_pwrgood(sb_pwrgood), .main_pwr_on(main_pwr_on),
      .pwr_pm_en(pwr_pm_en), .slp_pm_en(slp_pm_en), .legacy_mode(legacy_mode),
      .pwr_pm_clr(pwr_pm_clr), .pwr_gpe_clr(pwr_gpe_clr),
      .slp_pm_clr(slp_pm_clr), .slp_gpe_clr(slp_gpe_clr),
      .pwr_pm_sts(pwr_pm_sts), .pwr_gpe_sts(pwr_gpe_sts),
      .slp_pm_sts(slp_pm_sts), .slp_gpe_sts(slp_gpe_sts),
      .pwr_btn_fwd_n(pwr_btn_fwd_n), .off_req(off_req), .wake_req(wake_req));

   // vector: {pwr_n, slp_n, main, pm_en_p, pm_en_s, legacy, exp pp, pg, sp, sg, off, wake}
   localparam logic [11:0] VEC [8] = '{
      12'b010_110_110_001,
      12'b010_010_010_001,
      12'b100_110_001_100,
      12'b101_100_000_100,
      12'b011_111_000_010,
      12'b010_111_110_001,
      12'b011_110_110_000,
      12'b000_110_111_101
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] outs();
      return {pwr_pm_sts, pwr_gpe_sts, slp_pm_sts, slp_gpe_sts, off_req, wake_req};
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      pwr_pm_clr = 1'b1; slp_gpe_clr = 1'b1;
      cyc(1);
      pwr_pm_clr = 1'b0; slp_gpe_clr = 1'b0;
      cyc(2);
   endtask

   initial begin
      cyc(3);
      // R10: reset state
      chk("R10 outputs", {2'b0, outs()}, 8'h00);
      chk("R10 fwd", {7'b0, pwr_btn_fwd_n}, 8'h01);
      rst_n = 1'b1;
      cyc(1);

      // R7: press before standby power, then during and after the hold-off
      pwr_pm_en = 1'b1;
      pwr_btn_n = 1'b0;
      cyc(WAIT);
      chk("R2 fwd low on press", {7'b0, pwr_btn_fwd_n}, 8'h00);
      chk("R7 blocked without standby", {7'b0, pwr_gpe_sts}, 8'h00);
      sb_pwrgood = 1'b1;
      cyc(HOLD - 3);
      chk("R7 blocked during hold-off", {7'b0, pwr_gpe_sts}, 8'h00);
      cyc(WAIT);
      chk("R7 accepted after hold-off", {6'b0, pwr_pm_sts, pwr_gpe_sts}, 8'h03);
      chk("R8 wake with main off", {7'b0, wake_req}, 8'h01);

      // R6: clear while still pressed
      pwr_gpe_clr = 1'b1;
      cyc(1);
      pwr_gpe_clr = 1'b0;
      cyc(2);
      chk("R6 clear ignored while held", {6'b0, pwr_pm_sts, pwr_gpe_sts}, 8'h03);

      // R4: release keeps status
      pwr_btn_n = 1'b1;
      cyc(WAIT);
      chk("R2 fwd high on release", {7'b0, pwr_btn_fwd_n}, 8'h01);
      chk("R4 sticky after release", {6'b0, pwr_pm_sts, pwr_gpe_sts}, 8'h03);

      // R5: sleep status set, then clearing power leaves sleep alone
      slp_pm_en = 1'b1;
      slp_btn_n = 1'b0;
      cyc(WAIT);
      slp_btn_n = 1'b1;
      cyc(WAIT);
      pwr_gpe_clr = 1'b1;
      cyc(1);
      pwr_gpe_clr = 1'b0;
      cyc(1);
      chk("R5 coupled clear of power pair", {6'b0, pwr_pm_sts, pwr_gpe_sts}, 8'h00);
      chk("R5 sleep pair untouched", {6'b0, slp_pm_sts, slp_gpe_sts}, 8'h03);
      slp_pm_clr = 1'b1;
      cyc(1);
      slp_pm_clr = 1'b0;
      cyc(1);
      chk("R5 PM strobe clears sleep pair", {6'b0, slp_pm_sts, slp_gpe_sts}, 8'h00);

      // R1, R3, R8, R9: vector table
      for (int v = 0; v < 8; v++) begin
         pwr_btn_n   = VEC[v][11];
         slp_btn_n   = VEC[v][10];
         main_pwr_on = VEC[v][9];
         pwr_pm_en   = VEC[v][8];
         slp_pm_en   = VEC[v][7];
         legacy_mode = VEC[v][6];
         cyc(WAIT);
         chk($sformatf("R3 R8 R9 vector %0d", v), {2'b0, outs()}, {2'b0, VEC[v][5:0]});
         pwr_btn_n = 1'b1;
         slp_btn_n = 1'b1;
         cyc(WAIT);
         clear_all();
         legacy_mode = 1'b0;
         main_pwr_on = 1'b0;
      end

      // R1: glitch shorter than the filter window
      pwr_pm_en = 1'b1;
      pwr_btn_n = 1'b0;
      cyc(DEB - 2);
      pwr_btn_n = 1'b1;
      cyc(WAIT);
      chk("R1 glitch rejected", {6'b0, pwr_btn_fwd_n, pwr_gpe_sts}, 8'h02);

      // R1: no tick means no progress
      ms_tick = 1'b0;
      pwr_btn_n = 1'b0;
      cyc(3 * WAIT);
      chk("R1 stalled without tick", {7'b0, pwr_btn_fwd_n}, 8'h01);
      ms_tick = 1'b1;
      cyc(WAIT);
      chk("R1 accepted once ticking", {6'b0, pwr_btn_fwd_n, pwr_gpe_sts}, 8'h01);
      pwr_btn_n = 1'b1;
      cyc(WAIT);
      clear_all();

      // R7: dropping standby restarts the hold-off
      sb_pwrgood = 1'b0;
      cyc(2);
      sb_pwrgood = 1'b1;
      pwr_btn_n = 1'b0;
      cyc(HOLD - 2);
      chk("R7 hold-off restarted", {7'b0, pwr_gpe_sts}, 8'h00);
      cyc(WAIT);
      chk("R7 accepted after restart", {7'b0, pwr_gpe_sts}, 8'h01);
      pwr_btn_n = 1'b1;
      cyc(WAIT);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule